// File: doc/BRIEF.md
# Mixed-Width Register Bus Adapter

This bridge sits between a processor port that issues byte, halfword and word accesses and a register space in which every register has one fixed natural width. A computed width table, indexed by the 4-byte slot an address falls in, gives that width. When the access size equals the register width, the access goes through as one native operation. When the access is narrower than the register, the adapter reads the whole register and either extracts the addressed bytes or merges new bytes into it and writes it back. When the access is wider than the register, it is split into several native operations whose results are joined big-endian, so the lowest address is always the most significant part.

Each request is taken in one cycle when the adapter is idle. The adapter then stalls until every native sub-operation has finished and gives a one-cycle completion strobe, together with the read data and an error flag. Requests to unmapped slots, to offsets past the register space, with an unsupported size code, or at misaligned addresses finish at once with the error flag set and do nothing to the registers. The registers are plain byte-addressed storage behind a native port with a read latency of one cycle.

Top module: `mixed_width_adapter`

## Requirements
- R1: The register width comes from offset bits [8:2]. Bits [7:6] of the offset select it: 00 gives 1-byte registers, 01 gives 2-byte registers, 10 gives 4-byte registers, and 11 marks the slot unmapped. The size code is 0 for a byte, 1 for a halfword and 2 for a word. Data is right-justified on both data buses.
- R2: Several requests are errors: an offset of 0x200 or above, an unmapped slot, size code 3, or an address that is not a multiple of the access size. Such a request completes one cycle after acceptance with err high and rdata zero, and it leaves the storage unchanged.
- R3: When the access size equals the register width, one native operation is made. A read completes in the 3rd cycle after acceptance and a write in the 2nd. A write returns rdata zero.
- R4: A read narrower than the register reads the whole aligned register. It returns the addressed bytes, with the byte at the lower address being the more significant one. It completes in the 3rd cycle.
- R5: A write narrower than the register is a read, a merge and a write-back of the aligned register. Only the addressed bytes change. It completes in the 4th cycle.
- R6: An access wider than the register becomes n = size/width native operations at rising addresses, and the lowest address carries the most significant part. A read completes in cycle 2n+1 and a write in cycle n+1.
- R7: done is high for exactly one cycle per accepted request. req_ready is low from the accepting edge through the done cycle, and it is high again in the cycle after done.
- R8: After reset, req_ready is 1, done, err and rdata are 0, and all storage reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| req_addr | input | ADDR_W | Byte offset into the register space |
| req_wdata | input | 32 | Write data, right-justified |
| req_ready | output | 1 | Adapter idle; a request is accepted this cycle |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error flag, valid with done |
| rdata | output | 32 | Read data, right-justified, valid with done |

## Verification
The bench sends the same sizes into each width region, so that pass-through, read-merge-write and split cases are all tried and can be told apart by their results and their completion cycle. Directed sequences write a word into the byte region and read it back whole and in bytes, which shows the big-endian split order. A byte is merged into a word register and then read back, which shows that the neighbouring bytes survive the read-modify-write. Random traffic over the whole offset range, including offsets past the space and misaligned addresses, is compared against a byte-array model. Error writes are followed by readbacks, which shows they changed nothing.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OP,
      ST_CAP,
      ST_WB,
      ST_DONE
   } seq_state_t;

   // natural register width of a 4-byte slot, in bytes; 0 = unmapped
   function automatic logic [2:0] slot_width(input int unsigned slot);
      case ((slot >> 4) % 4)
         0:       return 3'd1;
         1:       return 3'd2;
         2:       return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   // access size code to byte count; 0 = unsupported code
   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [31:0] lane_mask(input int nb);
      return (nb >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
   endfunction

endpackage

// File: rtl/mwa_width_rom.sv
module mwa_width_rom #(
   parameter int SLOTS = 128,
   parameter int IDX_W = 7
) (
   input  logic [IDX_W-1:0] slot_idx,
   output logic [2:0]       nat_bytes
);

   logic [2:0] tbl [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign tbl[g] = mwa_pkg::slot_width(g);
   end

   assign nat_bytes = tbl[slot_idx];

endmodule

// File: rtl/mwa_regstore.sv
module mwa_regstore #(
   parameter int SPACE_BYTES = 512,
   parameter int OFF_W       = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nat_valid,
   input  logic             nat_write,
   input  logic [2:0]       nat_bytes,
   input  logic [OFF_W-1:0] nat_addr,
   input  logic [31:0]      nat_wdata,
   output logic [31:0]      nat_rdata
);

   logic [7:0]  mem [SPACE_BYTES];
   logic [31:0] rd_word;

   // big-endian gather of one native register
   always_comb begin
      rd_word = '0;
      for (int i = 0; i < 4; i++) begin
         if (i < int'(nat_bytes))
            rd_word = (rd_word << 8) | {24'h0, mem[nat_addr + OFF_W'(i)]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SPACE_BYTES; i++) mem[i] <= '0;
         nat_rdata <= '0;
      end else if (nat_valid) begin
         if (nat_write) begin
            for (int i = 0; i < 4; i++) begin
               if (i < int'(nat_bytes))
                  mem[nat_addr + OFF_W'(i)] <=
                     8'(nat_wdata >> (8 * (int'(nat_bytes) - 1 - i)));
            end
         end else begin
            nat_rdata <= rd_word;
         end
      end
   end

endmodule

// File: rtl/mwa_sequencer.sv
module mwa_sequencer
   import mwa_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int SPACE_BYTES = 512,
   parameter int OFF_W       = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic [2:0]        slot_bytes,
   output logic              req_ready,
   output logic              done,
   output logic              err,
   output logic [31:0]       rdata,
   output logic              nat_valid,
   output logic              nat_write,
   output logic [2:0]        nat_bytes,
   output logic [OFF_W-1:0]  nat_addr,
   output logic [31:0]       nat_wdata,
   input  logic [31:0]       nat_rdata
);

   seq_state_t       state_q;
   logic [2:0]       w_q, s_q, nops_q;
   logic [1:0]       k_q;
   logic [OFF_W-1:0] addr_q;
   logic             write_q, narrow_q, err_q;
   logic [31:0]      wdata_q, acc_q, rdata_q;

   // acceptance decode
   logic [2:0] acc_sb, acc_nops;
   logic       acc_bad;

   always_comb begin
      acc_sb  = size_bytes(req_size);
      acc_bad = (acc_sb == 3'd0)
             || (32'(req_addr) >= SPACE_BYTES)
             || (slot_bytes == 3'd0)
             || ((req_addr[1:0] & (acc_sb[1:0] - 2'd1)) != 2'd0);
      case (slot_bytes)
         3'd1:    acc_nops = acc_sb;
         3'd2:    acc_nops = acc_sb >> 1;
         default: acc_nops = acc_sb >> 2;
      endcase
      if (acc_nops == 3'd0) acc_nops = 3'd1;
   end

   // datapath for the sub-operations
   int               wb, sb, ob, nsh, psh;
   logic [OFF_W-1:0] aligned_addr, piece_addr;
   logic [31:0]      piece_data, rmw_word, narrow_rd, acc_next;
   logic             last_op;

   always_comb begin
      wb  = int'(w_q);
      sb  = int'(s_q);
      ob  = int'(addr_q[1:0]) & (wb - 1);
      nsh = 8 * (wb - ob - sb);
      if (nsh < 0) nsh = 0;
      psh = sb - (int'(k_q) + 1) * wb;
      if (psh < 0) psh = 0;
      aligned_addr = addr_q & ~(OFF_W'(w_q) - OFF_W'(1));
      piece_addr   = addr_q + OFF_W'(k_q) * OFF_W'(w_q);
      piece_data   = (wdata_q >> (8 * psh)) & lane_mask(wb);
      rmw_word     = (nat_rdata & ~(lane_mask(sb) << nsh))
                   | ((wdata_q & lane_mask(sb)) << nsh);
      narrow_rd    = (nat_rdata >> nsh) & lane_mask(sb);
      acc_next     = (wb >= 4) ? nat_rdata : ((acc_q << (8 * wb)) | nat_rdata);
      last_op      = ({1'b0, k_q} == (nops_q - 3'd1));
   end

   always_comb begin
      nat_valid = 1'b0;
      nat_write = 1'b0;
      nat_bytes = w_q;
      nat_addr  = piece_addr;
      nat_wdata = piece_data;
      case (state_q)
         ST_OP: begin
            nat_valid = 1'b1;
            nat_write = write_q && !narrow_q;
            nat_addr  = narrow_q ? aligned_addr : piece_addr;
         end
         ST_WB: begin
            nat_valid = 1'b1;
            nat_write = 1'b1;
            nat_addr  = aligned_addr;
            nat_wdata = acc_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         w_q      <= '0;
         s_q      <= '0;
         nops_q   <= '0;
         k_q      <= '0;
         addr_q   <= '0;
         write_q  <= 1'b0;
         narrow_q <= 1'b0;
         err_q    <= 1'b0;
         wdata_q  <= '0;
         acc_q    <= '0;
         rdata_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  w_q      <= slot_bytes;
                  s_q      <= acc_sb;
                  nops_q   <= acc_nops;
                  k_q      <= '0;
                  addr_q   <= req_addr[OFF_W-1:0];
                  write_q  <= req_write;
                  narrow_q <= (acc_sb < slot_bytes);
                  wdata_q  <= req_wdata;
                  acc_q    <= '0;
                  rdata_q  <= '0;
                  err_q    <= acc_bad;
                  state_q  <= acc_bad ? ST_DONE : ST_OP;
               end
            end
            ST_OP: begin
               if (nat_write) begin
                  if (last_op) state_q <= ST_DONE;
                  else k_q <= k_q + 2'd1;
               end else begin
                  state_q <= ST_CAP;
               end
            end
            ST_CAP: begin
               if (narrow_q) begin
                  if (write_q) begin
                     acc_q   <= rmw_word;
                     state_q <= ST_WB;
                  end else begin
                     rdata_q <= narrow_rd;
                     state_q <= ST_DONE;
                  end
               end else begin
                  acc_q <= acc_next;
                  if (last_op) begin
                     if (!write_q) rdata_q <= acc_next;
                     state_q <= ST_DONE;
                  end else begin
                     k_q     <= k_q + 2'd1;
                     state_q <= ST_OP;
                  end
               end
            end
            ST_WB:   state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign err       = done && err_q;
   assign rdata     = rdata_q;

endmodule

// File: rtl/mixed_width_adapter.sv
module mixed_width_adapter #(
   parameter int ADDR_W      = 10,
   parameter int SPACE_BYTES = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              req_ready,
   output logic              done,
   output logic              err,
   output logic [31:0]       rdata
);

   localparam int OFF_W = $clog2(SPACE_BYTES);
   localparam int SLOTS = SPACE_BYTES / 4;
   localparam int IDX_W = OFF_W - 2;

   if (SPACE_BYTES < 8 || (SPACE_BYTES & (SPACE_BYTES - 1)) != 0) begin : g_bad_space
      $error("register space must be a power of two of at least 8 bytes");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("address bus narrower than the register space");
   end

   logic [2:0]       slot_bytes;
   logic             nat_valid, nat_write;
   logic [2:0]       nat_bytes;
   logic [OFF_W-1:0] nat_addr;
   logic [31:0]      nat_wdata, nat_rdata;

   mwa_width_rom #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_rom (
      .slot_idx  (req_addr[OFF_W-1:2]),
      .nat_bytes (slot_bytes)
   );

   mwa_sequencer #(.ADDR_W(ADDR_W), .SPACE_BYTES(SPACE_BYTES), .OFF_W(OFF_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_size   (req_size),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .slot_bytes (slot_bytes),
      .req_ready  (req_ready),
      .done       (done),
      .err        (err),
      .rdata      (rdata),
      .nat_valid  (nat_valid),
      .nat_write  (nat_write),
      .nat_bytes  (nat_bytes),
      .nat_addr   (nat_addr),
      .nat_wdata  (nat_wdata),
      .nat_rdata  (nat_rdata)
   );

   mwa_regstore #(.SPACE_BYTES(SPACE_BYTES), .OFF_W(OFF_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .nat_valid (nat_valid),
      .nat_write (nat_write),
      .nat_bytes (nat_bytes),
      .nat_addr  (nat_addr),
      .nat_wdata (nat_wdata),
      .nat_rdata (nat_rdata)
   );

endmodule

// File: rtl/mwa_checker.sv
module mwa_checker #(
   parameter int ADDR_W      = 10,
   parameter int SPACE_BYTES = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              done,
   input logic              err,
   input logic [31:0]       rdata,
   input logic              nat_valid
);

   // R7
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   stall_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R7
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready);

   // R2
   range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (32'(req_addr) >= SPACE_BYTES)) |=> (done && err));

   // R2
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && rdata == 32'h0));

   // R7
   no_idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nat_valid |-> !req_ready);

endmodule

bind mixed_width_adapter mwa_checker #(.ADDR_W(ADDR_W), .SPACE_BYTES(SPACE_BYTES)) u_mwa_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .done      (done),
   .err       (err),
   .rdata     (rdata),
   .nat_valid (nat_valid)
);

// File: tb/test_mixed_width_adapter.sv
module test_mixed_width_adapter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = '0;
   logic [9:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, done, err;
   logic [31:0] rdata;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] mdl [512];

   always #10 clk = ~clk;

   mixed_width_adapter #(.ADDR_W(10), .SPACE_BYTES(512)) i_mixed_width_adapter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .done(done), .err(err), .rdata(rdata)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // R1 width table from offset bits [7:6]
   function automatic int exp_width(input logic [9:0] ad);
      case (ad[7:6])
         2'd0:    return 1;
         2'd1:    return 2;
         2'd2:    return 4;
         default: return 0;
      endcase
   endfunction

   function automatic int size_of(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
   endfunction

   task automatic run_txn(input logic wr, input logic [1:0] sz,
                          input logic [9:0] ad, input logic [31:0] wd);
      int sb, wb, n, exp_lat, lat;
      logic bad, stall_bad;
      logic [31:0] exp_rd;
      string tag;
      sb = size_of(sz);
      wb = exp_width(ad);
      bad = (sb == 0) || (ad >= 10'd512) || (wb == 0) || ((int'(ad) % sb) != 0);
      exp_rd = '0;
      if (bad) begin
         tag = "R2"; exp_lat = 1;
      end else if (sb == wb) begin
         tag = "R3"; exp_lat = wr ? 2 : 3;
      end else if (sb < wb) begin
         tag = wr ? "R5" : "R4"; exp_lat = wr ? 4 : 3;
      end else begin
         n = sb / wb;
         tag = "R6"; exp_lat = wr ? n + 1 : 2 * n + 1;
      end
      if (!bad && !wr)
         for (int i = 0; i < sb; i++) exp_rd = (exp_rd << 8) | {24'h0, mdl[int'(ad) + i]};

      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      stall_bad = 1'b0;
      while (done !== 1'b1) begin
         if (req_ready) stall_bad = 1'b1;
         @(negedge clk);
         lat++;
      end
      if (req_ready) stall_bad = 1'b1;
      check(tag, "rdata", rdata, exp_rd);
      check(tag, "err", {31'h0, err}, {31'h0, bad});
      check(tag, "latency", 32'(lat), 32'(exp_lat));
      check("R7", "stall", {31'h0, stall_bad}, 32'h0);
      @(negedge clk);
      check("R7", "done pulse/ready", {30'h0, done, req_ready}, 32'h1);

      if (!bad && wr)
         for (int i = 0; i < sb; i++)
            mdl[int'(ad) + i] = 8'(wd >> (8 * (sb - 1 - i)));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd7741));
      for (int i = 0; i < 512; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8", "ready", {31'h0, req_ready}, 32'h1);
      check("R8", "done/err", {30'h0, done, err}, 32'h0);
      check("R8", "rdata", rdata, 32'h0);
      rst_n = 1'b1;
      run_txn(1'b0, 2'd2, 10'h084, 32'h0);          // R8 storage zero

      // R6 word split over byte registers, big-endian
      run_txn(1'b1, 2'd2, 10'h010, 32'h11223344);
      run_txn(1'b0, 2'd2, 10'h010, 32'h0);
      run_txn(1'b0, 2'd0, 10'h012, 32'h0);          // R3 byte equals width
      run_txn(1'b0, 2'd1, 10'h012, 32'h0);          // R6 halfword over bytes
      run_txn(1'b1, 2'd2, 10'h048, 32'hCAFEF00D);   // R6 word over halfwords
      run_txn(1'b0, 2'd0, 10'h049, 32'h0);          // R4 byte in halfword
      // R5 merge into word register keeps neighbours
      run_txn(1'b1, 2'd2, 10'h080, 32'hAABBCCDD);
      run_txn(1'b1, 2'd0, 10'h081, 32'hFFFFFF5A);
      run_txn(1'b0, 2'd2, 10'h080, 32'h0);
      run_txn(1'b1, 2'd1, 10'h082, 32'h00001234);   // R5 low half
      run_txn(1'b0, 2'd1, 10'h080, 32'h0);          // R4 upper half at bits[1:0]=0
      run_txn(1'b0, 2'd1, 10'h082, 32'h0);
      // R2 errors, then readback proves no change
      run_txn(1'b1, 2'd2, 10'h0C4, 32'hDEADBEEF);
      run_txn(1'b1, 2'd2, 10'h200, 32'hDEADBEEF);
      run_txn(1'b1, 2'd1, 10'h081, 32'h0000BEEF);
      run_txn(1'b1, 2'd3, 10'h080, 32'hDEADBEEF);
      run_txn(1'b0, 2'd2, 10'h3FC, 32'h0);
      run_txn(1'b0, 2'd2, 10'h080, 32'h0);

      for (int t = 0; t < 500; t++) begin
         logic [1:0] sz;
         logic [9:0] ad;
         sz = ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         ad = 10'($urandom_range(0, 639));
         if (sz != 2'd3 && $urandom_range(0, 9) != 0)
            ad = ad & ~10'(size_of(sz) - 1);
         run_txn(1'($urandom_range(0, 1)), sz, ad, $urandom());
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule